// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block receives configuration words for a dual-loop frequency synthesizer over a three-wire serial port: a data line, a serial clock and a load strobe. All three wires are asynchronous to the block's system clock. Each one passes through a two-flop synchronizer, and the block detects its edges in the system clock domain. Every rising edge of the serial clock appends one bit to a 23-bit shift register, most significant bit first. A rising edge of the load strobe copies the register into one of four holding banks. The two lowest register bits choose the bank: reference word of the IF loop, reference word of the RF loop, divider word of the IF loop, or divider word of the RF loop.

Reference words and divider words use different field layouts. The block decodes each held word into plain outputs that the divider and charge-pump logic next to it reads directly. A reference word carries a 14-bit reference ratio, a 2-bit monitor-output select and a charge-pump current select. A divider word carries an 11-bit main count, a 7-bit swallow count, a prescaler modulus select, a phase-detector polarity bit and a monitor-output select bit. All pins are plain level signals. No port carries a data stream, so no port has valid/ready handshaking or back-pressure. The controller must keep the load strobe low while it shifts bits in.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is asserted and after it is released, both reference ratios read 3, both main counts read 3, both swallow counts read 0, and every single-bit field and monitor select reads 0.
- R2: Each rising edge of `ser_clk` shifts the sampled `ser_data` in at register bit 0 and moves every earlier bit up one place. The register keeps only the last 23 bits, so the first bit of a 23-bit frame ends up at bit 22 and bits sent earlier are lost.
- R3: A rising edge of `ser_load` copies the register into the bank chosen by bits 1 and 0: both 0 selects the IF reference bank, bit0=1 with bit1=0 the RF reference bank, bit0=0 with bit1=1 the IF divider bank, and both 1 the RF divider bank.
- R4: Reference word fields: bits 3:2 are the monitor select (bit 2 drives `*_mon_sel[0]`), bits 17:4 are the reference ratio with its LSB at bit 4, and bit 18 is the charge-pump select. Bits 22:19 have no effect.
- R5: Divider word fields: bit 2 is the monitor-output select, bit 3 the low-modulus select, bit 4 the phase polarity, bits 11:5 the swallow count (LSB at bit 5), and bits 22:12 the main count (LSB at bit 12).
- R6: `*_cp_hi` shows the charge-pump bit unchanged: 1 requests the high pump current and 0 the low one.
- R7: Rising edges of `ser_clk` that arrive while the synchronized `ser_load` is high do not change the shift register.
- R8: A load after fewer than 23 new bits latches the register as it stands, including bits left over from earlier frames.
- R9: A load changes only the selected bank. The other three banks keep their values.
- R10: Every input passes through two synchronizer flops. A change of `ser_load` or `ser_clk` that the system clock first samples at edge k takes effect at edge k+2 and shows on the outputs right after that edge.
- R11: The outputs change only after a rising edge of `ser_load`. Holding it high, or its falling edge, latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_load | input | 1 | Load strobe, asynchronous; its rising edge latches the word |
| if_ref_ratio | output | 14 | IF loop reference divide ratio |
| if_mon_sel | output | 2 | IF reference word monitor select |
| if_cp_hi | output | 1 | IF charge pump high-current select |
| rf_ref_ratio | output | 14 | RF loop reference divide ratio |
| rf_mon_sel | output | 2 | RF reference word monitor select |
| rf_cp_hi | output | 1 | RF charge pump high-current select |
| if_prog_n | output | 11 | IF main counter value |
| if_swallow_a | output | 7 | IF swallow counter value |
| if_phase_pos | output | 1 | IF phase detector polarity |
| if_mod_low | output | 1 | IF prescaler low-modulus select |
| if_mon_fout | output | 1 | IF divider word monitor-output select |
| rf_prog_n | output | 11 | RF main counter value |
| rf_swallow_a | output | 7 | RF swallow counter value |
| rf_phase_pos | output | 1 | RF phase detector polarity |
| rf_mod_low | output | 1 | RF prescaler low-modulus select |
| rf_mon_fout | output | 1 | RF divider word monitor-output select |

## Verification
The hardest state to reach from the pins is a shift register that holds a mix of old and new bits. It arises from overlong frames, short frames and serial clocks that arrive while the strobe is high, and it only shows on the outputs once a later load routes it somewhere. The stimulus sends a 25-bit frame and then pulses the serial clock under a held strobe. It then shifts a four-bit stub, which moves stale divider bits into the IF reference bank. A behavioural model built from sampled-input history predicts every output on every cycle, so a wrong synchronizer depth or a misplaced field shows up on the first edge where it matters.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int FRAME_W = 23;
  localparam int SEL_W   = 2;
  localparam int REF_W   = 14;
  localparam int PROG_W  = 11;
  localparam int SWAL_W  = 7;
  localparam int MON_W   = 2;
  localparam int SYNC_STAGES = 2;

  // held slices: everything above the two routing bits that a word uses
  localparam int REF_BANK_W = MON_W + REF_W + 1;
  localparam int DIV_BANK_W = 3 + SWAL_W + PROG_W;

  typedef enum logic [SEL_W-1:0] {
    TGT_IF_REF = 2'd0,
    TGT_RF_REF = 2'd1,
    TGT_IF_DIV = 2'd2,
    TGT_RF_DIV = 2'd3
  } tgt_e;

  // packing order follows the frame, most significant field first
  typedef struct packed {
    logic              cp_hi;
    logic [REF_W-1:0]  ratio;
    logic [MON_W-1:0]  mon_sel;
  } ref_word_t;

  typedef struct packed {
    logic [PROG_W-1:0] prog_n;
    logic [SWAL_W-1:0] swallow_a;
    logic              phase_pos;
    logic              mod_low;
    logic              mon_fout;
  } div_word_t;

  localparam ref_word_t REF_DEFAULT = '{cp_hi: 1'b0, ratio: REF_W'(3), mon_sel: '0};
  localparam div_word_t DIV_DEFAULT = '{prog_n: PROG_W'(3), swallow_a: '0,
                                        phase_pos: 1'b0, mod_low: 1'b0, mon_fout: 1'b0};

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int           W       = 17,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= d;
  end

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_load,
  output logic [REF_W-1:0]  if_ref_ratio,
  output logic [MON_W-1:0]  if_mon_sel,
  output logic              if_cp_hi,
  output logic [REF_W-1:0]  rf_ref_ratio,
  output logic [MON_W-1:0]  rf_mon_sel,
  output logic              rf_cp_hi,
  output logic [PROG_W-1:0] if_prog_n,
  output logic [SWAL_W-1:0] if_swallow_a,
  output logic              if_phase_pos,
  output logic              if_mod_low,
  output logic              if_mon_fout,
  output logic [PROG_W-1:0] rf_prog_n,
  output logic [SWAL_W-1:0] rf_swallow_a,
  output logic              rf_phase_pos,
  output logic              rf_mod_low,
  output logic              rf_mon_fout
);

  localparam int N_PLL = 2;

  // synchronized levels: [0] data, [1] serial clock, [2] load
  logic [2:0]         sync_lvl;
  logic [1:0]         ctrl_rise;
  logic               load_lvl;
  logic               load_rise;
  logic               shift_en;
  logic               shift_bit;
  logic [FRAME_W-1:0] frame_q;
  tgt_e               frame_tgt;

  ref_word_t ref_q [N_PLL];
  div_word_t div_q [N_PLL];

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_load, ser_clk, ser_data}),
    .sync_out (sync_lvl)
  );

  cfg_edge #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (sync_lvl[2:1]),
    .rise  (ctrl_rise)
  );

  assign shift_bit = sync_lvl[0];
  assign load_lvl  = sync_lvl[2];
  assign load_rise = ctrl_rise[1];
  assign shift_en  = ctrl_rise[0] & ~load_lvl;

  cfg_shift #(.W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (shift_en),
    .din   (shift_bit),
    .q     (frame_q)
  );

  assign frame_tgt = tgt_e'(frame_q[SEL_W-1:0]);

  for (genvar p = 0; p < N_PLL; p++) begin : g_pll
    localparam tgt_e REF_TGT = (p == 0) ? TGT_IF_REF : TGT_RF_REF;
    localparam tgt_e DIV_TGT = (p == 0) ? TGT_IF_DIV : TGT_RF_DIV;

    logic ref_load;
    logic div_load;
    assign ref_load = load_rise && (frame_tgt == REF_TGT);
    assign div_load = load_rise && (frame_tgt == DIV_TGT);

    cfg_bank #(.W(REF_BANK_W), .RST_VAL(REF_DEFAULT)) u_ref_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ref_load),
      .d     (frame_q[SEL_W +: REF_BANK_W]),
      .q     (ref_q[p])
    );

    cfg_bank #(.W(DIV_BANK_W), .RST_VAL(DIV_DEFAULT)) u_div_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (div_load),
      .d     (frame_q[SEL_W +: DIV_BANK_W]),
      .q     (div_q[p])
    );
  end

  assign if_ref_ratio = ref_q[0].ratio;
  assign if_mon_sel   = ref_q[0].mon_sel;
  assign if_cp_hi     = ref_q[0].cp_hi;
  assign rf_ref_ratio = ref_q[1].ratio;
  assign rf_mon_sel   = ref_q[1].mon_sel;
  assign rf_cp_hi     = ref_q[1].cp_hi;

  assign if_prog_n    = div_q[0].prog_n;
  assign if_swallow_a = div_q[0].swallow_a;
  assign if_phase_pos = div_q[0].phase_pos;
  assign if_mod_low   = div_q[0].mod_low;
  assign if_mon_fout  = div_q[0].mon_fout;
  assign rf_prog_n    = div_q[1].prog_n;
  assign rf_swallow_a = div_q[1].swallow_a;
  assign rf_phase_pos = div_q[1].phase_pos;
  assign rf_mod_low   = div_q[1].mod_low;
  assign rf_mon_fout  = div_q[1].mon_fout;

endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_rise,
  input logic        load_lvl,
  input logic        shift_en,
  input logic        shift_bit,
  input logic [22:0] frame_q,
  input logic [13:0] if_ref_ratio,
  input logic [13:0] rf_ref_ratio,
  input logic [10:0] if_prog_n,
  input logic [10:0] rf_prog_n,
  input logic [6:0]  rf_swallow_a
);

  // R2: one synchronized serial edge moves exactly one bit in at the bottom
  p_one_bit_per_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> frame_q == {$past(frame_q[21:0]), $past(shift_bit)});

  // R7: serial edges under a high strobe leave the register alone
  p_ignore_clk_under_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_lvl |=> $stable(frame_q));

  // R3: routing code 00 lands in the IF reference bank and nowhere else
  p_route_if_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && frame_q[1:0] == 2'b00) |=>
      (if_ref_ratio == $past(frame_q[17:4])) && $stable(rf_ref_ratio) && $stable(if_prog_n));

  // R5: routing code 11 fills the RF divider fields from their frame positions
  p_route_rf_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && frame_q[1:0] == 2'b11) |=>
      (rf_prog_n == $past(frame_q[22:12])) && (rf_swallow_a == $past(frame_q[11:5]))
      && $stable(if_prog_n) && $stable(if_ref_ratio));

  // R11: without a strobe edge nothing held moves
  p_hold_without_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(if_ref_ratio) && $stable(rf_ref_ratio) && $stable(if_prog_n)
      && $stable(rf_prog_n) && $stable(rf_swallow_a));

endmodule

bind synth_cfg_loader synth_cfg_loader_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_rise    (load_rise),
  .load_lvl     (load_lvl),
  .shift_en     (shift_en),
  .shift_bit    (shift_bit),
  .frame_q      (frame_q),
  .if_ref_ratio (if_ref_ratio),
  .rf_ref_ratio (rf_ref_ratio),
  .if_prog_n    (if_prog_n),
  .rf_prog_n    (rf_prog_n),
  .rf_swallow_a (rf_swallow_a)
);

// File: tb/test_synth_cfg_loader.sv
module test_synth_cfg_loader;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_load = 1'b0;

  logic [13:0] if_ref_ratio, rf_ref_ratio;
  logic [1:0]  if_mon_sel, rf_mon_sel;
  logic        if_cp_hi, rf_cp_hi;
  logic [10:0] if_prog_n, rf_prog_n;
  logic [6:0]  if_swallow_a, rf_swallow_a;
  logic        if_phase_pos, rf_phase_pos, if_mod_low, rf_mod_low, if_mon_fout, rf_mon_fout;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 1'b0;
  bit finished = 1'b0;

  // reference model state: input history (one entry per system edge) and frames
  logic [2:0]  h1 = '0, h2 = '0, h3 = '0;
  logic [22:0] m_sr = '0;
  logic [22:0] m_bank [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader i_synth_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load),
    .if_ref_ratio(if_ref_ratio), .if_mon_sel(if_mon_sel), .if_cp_hi(if_cp_hi),
    .rf_ref_ratio(rf_ref_ratio), .rf_mon_sel(rf_mon_sel), .rf_cp_hi(rf_cp_hi),
    .if_prog_n(if_prog_n), .if_swallow_a(if_swallow_a), .if_phase_pos(if_phase_pos),
    .if_mod_low(if_mod_low), .if_mon_fout(if_mon_fout),
    .rf_prog_n(rf_prog_n), .rf_swallow_a(rf_swallow_a), .rf_phase_pos(rf_phase_pos),
    .rf_mod_low(rf_mod_low), .rf_mon_fout(rf_mon_fout)
  );

  task automatic model_reset();
    h1 = '0; h2 = '0; h3 = '0; m_sr = '0;
    for (int i = 0; i < 4; i++) begin
      m_bank[i] = '0;
      if (i < 2) m_bank[i][17:4]  = 14'd3;   // R1 reference ratio default
      else       m_bank[i][22:12] = 11'd3;   // R1 main count default
    end
  endtask

  initial model_reset();

  // R10: a change sampled at edge k acts at edge k+2 (history depth 2 plus previous)
  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (h2[2] && !h3[2]) m_bank[m_sr[1:0]] = m_sr;                 // R3
      else if (h2[1] && !h3[1] && !h2[2]) m_sr = {m_sr[21:0], h2[0]}; // R2, R7
      h3 = h2; h2 = h1; h1 = {ser_load, ser_clk, ser_data};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R4 if ratio",  int'(if_ref_ratio), int'(m_bank[0][17:4]));
      chk("R4 if mon",    int'(if_mon_sel),   int'(m_bank[0][3:2]));
      chk("R6 if cp",     int'(if_cp_hi),     int'(m_bank[0][18]));
      chk("R4 rf ratio",  int'(rf_ref_ratio), int'(m_bank[1][17:4]));
      chk("R4 rf mon",    int'(rf_mon_sel),   int'(m_bank[1][3:2]));
      chk("R6 rf cp",     int'(rf_cp_hi),     int'(m_bank[1][18]));
      chk("R5 if n",      int'(if_prog_n),    int'(m_bank[2][22:12]));
      chk("R5 if a",      int'(if_swallow_a), int'(m_bank[2][11:5]));
      chk("R5 if flags",  int'({if_phase_pos, if_mod_low, if_mon_fout}), int'(m_bank[2][4:2]));
      chk("R5 rf n",      int'(rf_prog_n),    int'(m_bank[3][22:12]));
      chk("R5 rf a",      int'(rf_swallow_a), int'(m_bank[3][11:5]));
      chk("R5 rf flags",  int'({rf_phase_pos, rf_mod_low, rf_mon_fout}), int'(m_bank[3][4:2]));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      tick(2);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; tick(4);
    ser_load = 1'b0; tick(4);
  endtask

  function automatic logic [22:0] ref_frame(input bit rf, input int ratio, input int mon, input bit cp);
    logic [22:0] f;
    f = '0;
    f[0] = rf; f[1] = 1'b0;
    f[3:2] = mon[1:0];
    f[17:4] = ratio[13:0];
    f[18] = cp;
    f[22:19] = 4'b1010;        // R4 filler, no effect
    return f;
  endfunction

  function automatic logic [22:0] div_frame(input bit rf, input int n, input int a,
                                            input bit fc, input bit sw, input bit lds);
    logic [22:0] f;
    f = '0;
    f[0] = rf; f[1] = 1'b1;
    f[2] = lds; f[3] = sw; f[4] = fc;
    f[11:5] = a[6:0];
    f[22:12] = n[10:0];
    return f;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    summary();
  end

  initial begin
    logic [22:0] f, stub;
    tick(4);
    // R1: defaults while reset is held
    chk("R1 if ratio", int'(if_ref_ratio), 3);
    chk("R1 rf n",     int'(rf_prog_n), 3);
    chk("R1 if a",     int'(if_swallow_a), 0);
    chk("R1 flags",    int'({if_cp_hi, rf_cp_hi, if_mon_sel, rf_mon_fout}), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    tick(3);

    // R3, R4, R6: IF reference word
    send_bits(32'(ref_frame(1'b0, 1234, 1, 1'b1)), 23); pulse_load();
    chk("R3 if ratio", int'(if_ref_ratio), 1234);
    chk("R4 if mon",   int'(if_mon_sel), 1);
    chk("R6 if cp",    int'(if_cp_hi), 1);
    chk("R9 rf ratio kept", int'(rf_ref_ratio), 3);
    chk("R9 if n kept",     int'(if_prog_n), 3);

    // RF reference word, full-scale ratio
    send_bits(32'(ref_frame(1'b1, 16383, 2, 1'b0)), 23); pulse_load();
    chk("R3 rf ratio", int'(rf_ref_ratio), 16383);
    chk("R4 rf mon",   int'(rf_mon_sel), 2);
    chk("R6 rf cp",    int'(rf_cp_hi), 0);
    chk("R9 if ratio kept", int'(if_ref_ratio), 1234);

    // R5: IF divider, all-ones counts
    send_bits(32'(div_frame(1'b0, 2047, 127, 1'b1, 1'b0, 1'b1)), 23); pulse_load();
    chk("R5 if n", int'(if_prog_n), 2047);
    chk("R5 if a", int'(if_swallow_a), 127);
    chk("R5 if fc/sw/lds", int'({if_phase_pos, if_mod_low, if_mon_fout}), 3'b101);

    // RF divider
    send_bits(32'(div_frame(1'b1, 100, 5, 1'b0, 1'b1, 1'b0)), 23); pulse_load();
    chk("R5 rf n", int'(rf_prog_n), 100);
    chk("R5 rf a", int'(rf_swallow_a), 5);
    chk("R5 rf fc/sw/lds", int'({rf_phase_pos, rf_mod_low, rf_mon_fout}), 3'b010);

    // R2: 25-bit frame, the two leading bits fall off the top
    f = div_frame(1'b1, 777, 33, 1'b1, 1'b1, 1'b1);
    send_bits({7'b0, 2'b10, f}, 25); pulse_load();
    chk("R2 rf n", int'(rf_prog_n), 777);
    chk("R2 rf a", int'(rf_swallow_a), 33);
    chk("R9 if n kept", int'(if_prog_n), 2047);

    // R7: serial edges under a held strobe are dropped, then reload the same word
    ser_data = 1'b1;
    ser_load = 1'b1; tick(4);
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b1; tick(3); ser_clk = 1'b0; tick(3);
    end
    ser_load = 1'b0; tick(4);
    pulse_load();
    chk("R7 rf n", int'(rf_prog_n), 777);
    chk("R7 rf a", int'(rf_swallow_a), 33);

    // R8: four-bit stub over the leftover divider word routes to IF reference
    stub = {f[18:0], 4'b0000};
    send_bits(32'h0, 4); pulse_load();
    chk("R8 if ratio", int'(if_ref_ratio), int'(stub[17:4]));
    chk("R8 if mon",   int'(if_mon_sel), int'(stub[3:2]));
    chk("R8 if cp",    int'(if_cp_hi), int'(stub[18]));

    // R10: strobe raised at a falling edge, outputs move after the third rising edge
    send_bits(32'(ref_frame(1'b0, 500, 3, 1'b0)), 23);
    ser_load = 1'b1;
    tick(1); chk("R10 before k+1", int'(if_ref_ratio), int'(stub[17:4]));
    tick(1); chk("R10 before k+2", int'(if_ref_ratio), int'(stub[17:4]));
    tick(1); chk("R10 at k+2",     int'(if_ref_ratio), 500);

    // R11: level high and falling edge latch nothing; new bits alone change nothing
    tick(6);
    ser_load = 1'b0; tick(4);
    send_bits(32'(ref_frame(1'b0, 42, 0, 1'b1)), 23);
    tick(4);
    chk("R11 if ratio held", int'(if_ref_ratio), 500);
    chk("R11 if cp held",    int'(if_cp_hi), 0);
    pulse_load();
    chk("R11 if ratio loaded", int'(if_ref_ratio), 42);

    // R1: a second reset restores every default
    rst_n = 1'b0; tick(3);
    chk("R1 if ratio again", int'(if_ref_ratio), 3);
    chk("R1 rf n again",     int'(rf_prog_n), 3);
    chk("R1 rf a again",     int'(rf_swallow_a), 0);
    rst_n = 1'b1; tick(4);

    summary();
  end

endmodule